// File: doc/BRIEF.md
# Run-Ahead Checkpoint and Poison Tracker

This block controls the run-ahead mode of a single-issue, in-order pipeline. In normal mode every result retires into the main register file. When a load misses the cache, or the store buffer fills, the block freezes the main register file and the return address stack as a checkpoint. It then lets the pipeline keep issuing speculatively instead of stalling. Results computed during this run-ahead pass go only to a shadow register file. Each register also carries a poison flag that marks a value the pipeline does not have yet.

The poison flag of a destination is the OR of the flags of its sources, so any consumer of missing data is marked at once and needs no execution unit. A memory access whose address is poisoned is never sent to the cache. When the outstanding data returns, the block drops every speculative result and resumes from the checkpoint. Entering and leaving run-ahead both take effect at the clock edge of the triggering event, so the next instruction already sees the new mode.

Top module: `scout_tracker`

## Requirements
- R1: After reset the block is in normal mode. All poison flags are clear, both register files read zero and the return stack pointer is zero. `ras_top` reads entry 3 of a 4-deep stack.
- R2: Instruction kinds are encoded on `iss_kind` as 0 ALU, 1 LOAD, 2 STORE and 3 OTHER. A valid LOAD with `iss_miss` high in normal mode writes no register. It sets the poison flag of its destination, and `scouting` is high from the next cycle on.
- R3: `sb_full` in normal mode also enters run-ahead at the next edge. An instruction issued in that same cycle still retires into the main register file, and no poison flag is set by the entry itself.
- R4: In run-ahead, the destination poison of an ALU op is the OR of the poison flags of `iss_src_a` and, when `iss_use_b` is high, of `iss_src_b`. For a LOAD it is the poison of `iss_src_a` ORed with `iss_miss`. `iss_nt` shows this value in the same cycle. A destination whose sources are all clear has its flag cleared.
- R5: During run-ahead the main register file never changes. Non-poisoned ALU and LOAD results go to the shadow file, and `rd_live` reads the shadow file while `rd_main` reads the main file.
- R6: `data_ret` while scouting raises `restore` in the same cycle. From the next cycle the block is in normal mode with all poison flags clear, and `rd_live` again reads the main file.
- R7: The return stack (push wins over pop) is saved when run-ahead is entered and restored on exit. Pushes and pops made during run-ahead are discarded.
- R8: `mem_req` is high for a valid LOAD or STORE only when its address register `iss_src_a` is not poisoned.
- R9: A load miss during run-ahead poisons its destination but takes no new checkpoint. The first `data_ret` restores the state saved at the original entry.
- R10: `data_ret` in normal mode and `sb_full` during run-ahead have no effect on mode, registers or poison flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_kind | input | 2 | 0 ALU, 1 LOAD, 2 STORE, 3 OTHER |
| iss_dst | input | 4 | Destination register |
| iss_src_a | input | 4 | First source; address register for LOAD/STORE |
| iss_src_b | input | 4 | Second source |
| iss_use_b | input | 1 | Second source is read |
| iss_result | input | 16 | Result value to write if not poisoned |
| iss_miss | input | 1 | The issuing LOAD missed the cache |
| sb_full | input | 1 | Store buffer full event |
| data_ret | input | 1 | Outstanding miss data returned |
| ras_push | input | 1 | Push `ras_addr` on the return stack |
| ras_pop | input | 1 | Pop the return stack |
| ras_addr | input | 12 | Return address to push |
| rd_sel | input | 4 | Register read select |
| scouting | output | 1 | Run-ahead mode active |
| restore | output | 1 | Checkpoint is being restored this cycle |
| iss_nt | output | 1 | Destination of the issuing instruction is poisoned |
| mem_req | output | 1 | Memory access forwarded to the cache |
| nt_vec | output | 16 | Poison flag per register |
| rd_main | output | 16 | Main register file at `rd_sel` |
| rd_live | output | 16 | Currently visible register value at `rd_sel` |
| ras_top | output | 12 | Top of the return stack |

## Verification
A directed run first builds a dependency chain. A miss feeds an ALU op, which feeds a load and a store, and then a redefinition clears the poison. This separates correct OR-propagation from stale or sticky flags. Overlapping events follow: a second miss, `sb_full` while scouting and `data_ret` while normal. They show whether the checkpoint is retaken or stray events leak through. A long random stream with biased miss, return and store-buffer rates is then compared against a behavioural model every cycle. It covers entry-cycle retirement, push/pop collisions and back-to-back enter/exit, which the directed part reaches only once.

// File: rtl/scout_tracker.sv
module scout_tracker #(
  parameter int NREG      = 16,
  parameter int W         = 16,
  parameter int RAS_DEPTH = 4,
  parameter int AW        = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [1:0]              iss_kind,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [$clog2(NREG)-1:0] iss_src_a,
  input  logic [$clog2(NREG)-1:0] iss_src_b,
  input  logic                    iss_use_b,
  input  logic [W-1:0]            iss_result,
  input  logic                    iss_miss,
  input  logic                    sb_full,
  input  logic                    data_ret,
  input  logic                    ras_push,
  input  logic                    ras_pop,
  input  logic [AW-1:0]           ras_addr,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic                    scouting,
  output logic                    restore,
  output logic                    iss_nt,
  output logic                    mem_req,
  output logic [NREG-1:0]         nt_vec,
  output logic [W-1:0]            rd_main,
  output logic [W-1:0]            rd_live,
  output logic [AW-1:0]           ras_top
);
  localparam int RW = $clog2(NREG);
  localparam int PW = $clog2(RAS_DEPTH);
  localparam logic [1:0] K_ALU = 2'd0, K_LD = 2'd1, K_ST = 2'd2;

  logic [NREG-1:0][W-1:0]       rf_main, rf_shad, main_nx;
  logic [NREG-1:0]              nt;
  logic [RAS_DEPTH-1:0][AW-1:0] ras, ras_nx, ras_ck;
  logic [PW-1:0]                ptr, ptr_nx, ptr_ck;

  wire a_nt    = scouting & nt[iss_src_a];
  wire b_nt    = scouting & iss_use_b & nt[iss_src_b];
  wire is_mem  = iss_kind == K_LD || iss_kind == K_ST;
  wire dst_wr  = iss_valid & (iss_kind == K_ALU || iss_kind == K_LD);
  wire miss_ld = iss_valid & (iss_kind == K_LD) & iss_miss;
  wire dst_nt  = iss_kind == K_ALU ? (a_nt | b_nt) : (iss_kind == K_LD ? (a_nt | iss_miss) : 1'b0);
  wire wr_en   = dst_wr & ~dst_nt;
  wire enter   = ~scouting & (miss_ld | sb_full);

  assign iss_nt  = iss_valid & dst_nt;
  assign mem_req = iss_valid & is_mem & ~a_nt;
  assign restore = scouting & data_ret;
  assign nt_vec  = nt;
  assign rd_main = rf_main[rd_sel];
  assign rd_live = scouting ? rf_shad[rd_sel] : rf_main[rd_sel];
  assign ras_top = ras[ptr - PW'(1)];

  always_comb begin
    main_nx = rf_main;
    if (wr_en) main_nx[iss_dst] = iss_result;
  end

  always_comb begin
    ras_nx = ras;
    ptr_nx = ptr;
    if (ras_push) begin
      ras_nx[ptr] = ras_addr;
      ptr_nx      = ptr + PW'(1);
    end else if (ras_pop) begin
      ptr_nx = ptr - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_main  <= '0;
      rf_shad  <= '0;
      nt       <= '0;
      scouting <= 1'b0;
      ras      <= '0;
      ptr      <= '0;
      ras_ck   <= '0;
      ptr_ck   <= '0;
    end else if (!scouting) begin
      rf_main <= main_nx;
      ras     <= ras_nx;
      ptr     <= ptr_nx;
      if (enter) begin
        scouting <= 1'b1;
        rf_shad  <= main_nx;
        nt       <= miss_ld ? (NREG'(1) << iss_dst) : '0;
        ras_ck   <= ras_nx;
        ptr_ck   <= ptr_nx;
      end
    end else if (data_ret) begin
      scouting <= 1'b0;
      nt       <= '0;
      ras      <= ras_ck;
      ptr      <= ptr_ck;
    end else begin
      if (wr_en)  rf_shad[iss_dst] <= iss_result;
      if (dst_wr) nt[iss_dst]      <= dst_nt;
      ras <= ras_nx;
      ptr <= ptr_nx;
    end
  end

  a_r2_enter_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !scouting && miss_ld |=> scouting && nt[$past(iss_dst)]);
  a_r3_enter_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    !scouting && sb_full |=> scouting);
  a_r5_main_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    scouting |=> $stable(rf_main));
  a_r6_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    scouting && data_ret |=> !scouting && nt == '0);
  a_r7_ckpt_held: assert property (@(posedge clk) disable iff (!rst_n)
    scouting && !data_ret |=> $stable(ras_ck) && $stable(ptr_ck));
  a_r8_no_poison_addr: assert property (@(posedge clk) disable iff (!rst_n)
    scouting && iss_valid && nt[iss_src_a] |-> !mem_req);
  a_r9_single_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
    scouting && !data_ret |=> scouting);
  a_r10_normal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !scouting |-> nt == '0);
endmodule

// File: tb/test_scout_tracker.sv
module test_scout_tracker;
  localparam int NREG = 16, W = 16, D = 4, AW = 12;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_use_b = 0, iss_miss = 0, sb_full = 0, data_ret = 0;
  logic ras_push = 0, ras_pop = 0;
  logic [1:0] iss_kind = 0;
  logic [3:0] iss_dst = 0, iss_src_a = 0, iss_src_b = 0, rd_sel = 0;
  logic [W-1:0] iss_result = 0;
  logic [AW-1:0] ras_addr = 0;
  logic scouting, restore, iss_nt, mem_req;
  logic [NREG-1:0] nt_vec;
  logic [W-1:0] rd_main, rd_live;
  logic [AW-1:0] ras_top;

  scout_tracker i_scout_tracker (.*);

  always #2.5 clk = ~clk;

  int checks = 0, bad = 0, cyc = 0;

  logic [W-1:0]  m_main [NREG];
  logic [W-1:0]  m_shad [NREG];
  logic          m_nt   [NREG];
  logic [AW-1:0] m_ras  [D];
  logic [AW-1:0] m_rck  [D];
  int m_ptr, m_pck;
  logic m_scout;

  function automatic logic lnt(input int r);
    return m_scout & m_nt[r];
  endfunction

  function automatic logic e_dnt();
    if (iss_kind == 0) return lnt(iss_src_a) | (iss_use_b & lnt(iss_src_b));
    if (iss_kind == 1) return lnt(iss_src_a) | iss_miss;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d got=%0h exp=%0h", tag, cyc, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [NREG-1:0] ev;
    for (int i = 0; i < NREG; i++) ev[i] = lnt(i);
    chk("R6 scouting", scouting, m_scout);
    chk("R6 restore", restore, m_scout & data_ret);
    chk("R4 nt_vec", nt_vec, ev);
    chk("R4 iss_nt", iss_nt, iss_valid & e_dnt());
    chk("R8 mem_req", mem_req, iss_valid & (iss_kind == 1 || iss_kind == 2) & ~lnt(iss_src_a));
    chk("R5 rd_main", rd_main, m_main[rd_sel]);
    chk("R5 rd_live", rd_live, m_scout ? m_shad[rd_sel] : m_main[rd_sel]);
    chk("R7 ras_top", ras_top, m_ras[(m_ptr + D - 1) % D]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin m_main[i] = 0; m_shad[i] = 0; m_nt[i] = 0; end
      for (int i = 0; i < D; i++) begin m_ras[i] = 0; m_rck[i] = 0; end
      m_ptr = 0; m_pck = 0; m_scout = 0;
    end else begin
      logic dn, wr, ret_ex;
      dn = e_dnt();
      wr = iss_valid && (iss_kind == 0 || iss_kind == 1) && !dn;
      ret_ex = m_scout && data_ret;
      if (!ret_ex) begin
        if (ras_push) begin m_ras[m_ptr] = ras_addr; m_ptr = (m_ptr + 1) % D; end
        else if (ras_pop) m_ptr = (m_ptr + D - 1) % D;
      end
      if (!m_scout) begin
        if (wr) m_main[iss_dst] = iss_result;
        if ((iss_valid && iss_kind == 1 && iss_miss) || sb_full) begin
          for (int i = 0; i < NREG; i++) begin m_shad[i] = m_main[i]; m_nt[i] = 0; end
          if (iss_valid && iss_kind == 1 && iss_miss) m_nt[iss_dst] = 1;
          for (int i = 0; i < D; i++) m_rck[i] = m_ras[i];
          m_pck = m_ptr;
          m_scout = 1;
        end
      end else if (ret_ex) begin
        m_scout = 0;
        for (int i = 0; i < NREG; i++) m_nt[i] = 0;
        for (int i = 0; i < D; i++) m_ras[i] = m_rck[i];
        m_ptr = m_pck;
      end else begin
        if (wr) m_shad[iss_dst] = iss_result;
        if (iss_valid && (iss_kind == 0 || iss_kind == 1)) m_nt[iss_dst] = dn;
      end
    end
  end

  task automatic step(input logic v, input logic [1:0] k, input int d, input int a, input int b,
                      input logic ub, input int res, input logic miss, input logic full,
                      input logic ret, input logic push, input logic pop, input int ra, input int sel);
    @(negedge clk);
    iss_valid = v; iss_kind = k; iss_dst = 4'(d); iss_src_a = 4'(a); iss_src_b = 4'(b);
    iss_use_b = ub; iss_result = W'(res); iss_miss = miss; sb_full = full; data_ret = ret;
    ras_push = push; ras_pop = pop; ras_addr = AW'(ra); rd_sel = 4'(sel);
    #1;
    cyc++;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 scouting", scouting, 0);
    chk("R1 nt_vec", nt_vec, 0);
    chk("R1 rd_live", rd_live, 0);
    chk("R1 ras_top", ras_top, 0);

    step(1, 0, 1, 0, 0, 0, 'h11, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 2, 0, 0, 0, 'h22, 0, 0, 0, 1, 0, 'h100, 1);
    chk("R1 rd_main after write", rd_main, 'h11);
    step(1, 1, 3, 1, 0, 0, 'h33, 1, 0, 0, 0, 0, 0, 2);
    chk("R2 miss poisons dst", iss_nt, 1);
    step(1, 0, 4, 3, 1, 1, 'h44, 0, 0, 0, 0, 0, 0, 3);
    chk("R2 scouting next cycle", scouting, 1);
    chk("R4 OR of sources", iss_nt, 1);
    chk("R2 miss dst unwritten", rd_live, 0);
    step(1, 0, 1, 2, 0, 0, 'h55, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 clean sources", iss_nt, 0);
    step(1, 2, 0, 3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R5 shadow write", rd_live, 'h55);
    chk("R5 main frozen", rd_main, 'h11);
    chk("R8 poisoned store address", mem_req, 0);
    step(1, 1, 5, 4, 0, 0, 'h66, 0, 0, 0, 0, 0, 0, 4);
    chk("R8 poisoned load address", mem_req, 0);
    chk("R4 poisoned address load", iss_nt, 1);
    step(1, 0, 3, 2, 0, 0, 'h77, 0, 0, 0, 0, 1, 0, 3);
    step(1, 1, 6, 2, 0, 0, 'h88, 1, 0, 0, 1, 0, 'h200, 3);
    chk("R4 redefinition clears", nt_vec[3], 0);
    chk("R8 clean address load sent", mem_req, 1);
    chk("R9 miss in scout poisons", iss_nt, 1);
    step(0, 3, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 6);
    chk("R7 push during scout", ras_top, 'h200);
    chk("R9 second miss flag", nt_vec[6], 1);
    step(0, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R10 sb_full ignored in scout", scouting, 1);
    chk("R6 restore pulse", restore, 1);
    step(0, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R6 back to normal", scouting, 0);
    chk("R6 poison cleared", nt_vec, 0);
    chk("R6 live reads main", rd_live, 'h11);
    chk("R7 stack restored", ras_top, 'h100);
    chk("R10 data_ret ignored in normal", restore, 0);
    step(1, 0, 7, 0, 0, 0, 'h77, 0, 1, 0, 0, 0, 0, 7);
    step(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7);
    chk("R3 entry on full", scouting, 1);
    chk("R3 entry cycle retired", rd_main, 'h77);
    chk("R3 no poison from full", nt_vec, 0);
    chk("R10 normal data_ret left mode", rd_live, 'h77);
    step(0, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
           $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
           1'($urandom_range(0, 1)), $urandom_range(0, 65535),
           r < 12, $urandom_range(0, 99) < 3, $urandom_range(0, 99) < 6,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 4095), $urandom_range(0, 15));
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule